// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a small processor. Each cycle it takes a source operand, a destination operand and a three-bit operation code. It computes a result and a write-enable that tells the register file whether to store that result in the destination register. It also produces a four-bit condition status: zero, negative, carry and overflow.

The result and write-enable are combinational. The status word sits in a register that loads only when the valid strobe is high and the operation code is defined. Every flag-affecting operation rebuilds all four flags from scratch, so no flag survives from an earlier operation.

The supported operations are add, subtract, compare, OR, XOR and bit-test. Compare and bit-test only affect the flags and never write back. After a subtraction or a compare, carry means a borrow occurred.

Top module: `int_alu_flags`

## Requirements
- R1: Operation code 0 (add) drives `result_o` with dst + src modulo 2^32 and raises `wr_en_o` while `valid_i` is high. Its carry is set exactly when the sum is smaller than either operand (unsigned wrap).
- R2: For add, overflow is set exactly when src and dst share bit 31 and the sum's bit 31 differs from it.
- R3: Operation code 1 (subtract) drives `result_o` with dst - src and raises `wr_en_o` while `valid_i` is high. Its carry is set exactly when src > dst as unsigned values (borrow).
- R4: For subtract, overflow is set exactly when bits 31 of src and dst differ and the result's bit 31 differs from dst bit 31.
- R5: Operation code 2 (compare) drives `result_o` with dst - src and sets all four flags by the subtract rules, but `wr_en_o` stays low.
- R6: Operation codes 3 (OR) and 4 (XOR) drive `result_o` with the bitwise OR or XOR of the operands and raise `wr_en_o` while `valid_i` is high. They load C = 0 and V = 0.
- R7: Operation code 5 (bit-test) drives `result_o` with src AND dst and loads C = 0 and V = 0, with `wr_en_o` low.
- R8: For every defined operation, Z is loaded with (result == 0) and N with result bit 31. No flag keeps its previous value.
- R9: `status_o` is {V, C, N, Z} in bits [3:0], from most to least significant. It loads on a rising clock edge with `valid_i` high and a defined operation code, and holds its value otherwise.
- R10: A synchronous reset (`rst` high at a rising edge) clears `status_o` to 0.
- R11: Operation codes 6 and 7 give `result_o` = 0 and `wr_en_o` = 0, and leave `status_o` unchanged even when `valid_i` is high.
- R12: `wr_en_o` is low whenever `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status word |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 or, 4 xor, 5 btst) |
| src_i | input | 32 | Source (first) operand |
| dst_i | input | 32 | Destination (second) operand |
| result_o | output | 32 | Combinational result |
| wr_en_o | output | 1 | Result is to be written to the destination register |
| status_o | output | 4 | Registered flags {V, C, N, Z} |

## Verification
The bench targets the arithmetic edges and the flag-clearing rules.

- Add is driven across both the unsigned and the signed wrap points, including the case where two sign-bit-only operands sum to zero. A design that took carry from bit 31, or that tested overflow without the same-sign condition, gets Z, C or V wrong there.
- Subtract and compare are driven with operand orders that produce a borrow and that cross the signed boundary from both sides. An inverted borrow or swapped compare operands shows up in C.
- Logical operations follow ones that left C and V set, so flags that leak through are caught.
- Reserved codes and idle cycles are applied after known flag states, so a status word that loads when it should not is caught.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

   typedef enum logic [2:0] {
      OPC_ADD  = 3'd0,
      OPC_SUB  = 3'd1,
      OPC_CMP  = 3'd2,
      OPC_OR   = 3'd3,
      OPC_XOR  = 3'd4,
      OPC_BTST = 3'd5,
      OPC_RSV6 = 3'd6,
      OPC_RSV7 = 3'd7
   } opc_e;

   typedef struct packed {
      logic v;
      logic c;
      logic n;
      logic z;
   } flags_t;

   localparam int unsigned OPC_BITS  = 3;
   localparam int unsigned FLAG_BITS = 4;

   typedef enum logic [1:0] {
      LSEL_OR  = 2'd0,
      LSEL_XOR = 2'd1,
      LSEL_AND = 2'd2
   } lsel_e;

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned CARRY_STYLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o,
   output logic             ovf_o
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ialu_addsub: WIDTH must be at least 2");
      end
      if (CARRY_STYLE > 1) begin : g_bad_style
         $error("ialu_addsub: CARRY_STYLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH:0] ext;

   generate
      if (CARRY_STYLE == 0) begin : g_ext_carry
         always_comb begin
            if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
            else       ext = {1'b0, a_i} + {1'b0, b_i};
         end
         assign res_o   = ext[MSB:0];
         assign carry_o = ext[WIDTH];
      end else begin : g_cmp_carry
         always_comb begin
            ext = '0;
            if (sub_i) ext[MSB:0] = a_i - b_i;
            else       ext[MSB:0] = a_i + b_i;
         end
         assign res_o   = ext[MSB:0];
         assign carry_o = sub_i ? (b_i > a_i)
                                : ((ext[MSB:0] < a_i) || (ext[MSB:0] < b_i));
      end
   endgenerate

   logic same_sign;
   assign same_sign = (a_i[MSB] == b_i[MSB]);
   assign ovf_o = (sub_i ? !same_sign : same_sign) && (res_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
   import ialu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  lsel_e            sel_i,
   output logic [WIDTH-1:0] res_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ialu_logic: WIDTH must be positive");
      end
   endgenerate

   always_comb begin
      unique case (sel_i)
         LSEL_OR:  res_o = a_i | b_i;
         LSEL_XOR: res_o = a_i ^ b_i;
         LSEL_AND: res_o = a_i & b_i;
         default:  res_o = '0;
      endcase
   end

endmodule

// File: rtl/ialu_flagreg.sv
module ialu_flagreg
   import ialu_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   load_i,
   input  flags_t next_i,
   output flags_t flags_o
);
   always_ff @(posedge clk) begin
      if (rst)         flags_o <= '0;
      else if (load_i) flags_o <= next_i;
   end

   // R10
   flag_reset_chk: assert property (@(posedge clk) rst |=> (flags_o == '0));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(flags_o));

   // R9
   flag_load_chk: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (flags_o == $past(next_i)));

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import ialu_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned CARRY_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                valid_i,
   input  logic [OPC_BITS-1:0] op_i,
   input  logic [WIDTH-1:0]    src_i,
   input  logic [WIDTH-1:0]    dst_i,
   output logic [WIDTH-1:0]    result_o,
   output logic                wr_en_o,
   output logic [FLAG_BITS-1:0] status_o
);
   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu_flags: WIDTH must be at least 2");
      end
   endgenerate

   opc_e opc;
   assign opc = opc_e'(op_i);

   logic is_arith, is_sub, is_logic, is_known, writes;
   lsel_e lsel;

   always_comb begin
      is_arith = 1'b0;
      is_sub   = 1'b0;
      is_logic = 1'b0;
      writes   = 1'b0;
      lsel     = LSEL_AND;
      unique case (opc)
         OPC_ADD:  begin is_arith = 1'b1; writes = 1'b1; end
         OPC_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; writes = 1'b1; end
         OPC_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; end
         OPC_OR:   begin is_logic = 1'b1; lsel = LSEL_OR;  writes = 1'b1; end
         OPC_XOR:  begin is_logic = 1'b1; lsel = LSEL_XOR; writes = 1'b1; end
         OPC_BTST: begin is_logic = 1'b1; lsel = LSEL_AND; end
         default:  begin end
      endcase
      is_known = is_arith || is_logic;
   end

   logic [WIDTH-1:0] as_res, lg_res;
   logic             as_carry, as_ovf;

   ialu_addsub #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_addsub (
      .a_i     (dst_i),
      .b_i     (src_i),
      .sub_i   (is_sub),
      .res_o   (as_res),
      .carry_o (as_carry),
      .ovf_o   (as_ovf)
   );

   ialu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (dst_i),
      .b_i   (src_i),
      .sel_i (lsel),
      .res_o (lg_res)
   );

   always_comb begin
      if (is_arith)      result_o = as_res;
      else if (is_logic) result_o = lg_res;
      else               result_o = '0;
   end

   assign wr_en_o = valid_i && writes;

   flags_t next_flags;
   always_comb begin
      next_flags   = '0;
      next_flags.z = (result_o == '0);
      next_flags.n = result_o[MSB];
      if (is_arith) begin
         next_flags.c = as_carry;
         next_flags.v = as_ovf;
      end
   end

   flags_t flags_q;
   ialu_flagreg u_flagreg (
      .clk     (clk),
      .rst     (rst),
      .load_i  (valid_i && is_known),
      .next_i  (next_flags),
      .flags_o (flags_q)
   );

   assign status_o = flags_q;

   // R12
   wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |-> !wr_en_o);

   // R5
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd2 || op_i == 3'd5) |-> !wr_en_o);

   // R11
   rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i[2:1] == 2'b11) |-> (result_o == '0 && !wr_en_o));

   // R11
   rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (op_i[2:1] == 2'b11) |=> $stable(status_o));

   // R6
   logic_cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5))
      |=> (status_o[3:2] == 2'b00));

   // R8
   zn_track_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i <= 3'd5)
      |=> (status_o[0] == ($past(result_o) == '0)
           && status_o[1] == $past(result_o[MSB])));

endmodule

// File: tb/int_alu_flags_bench.sv
module int_alu_flags_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [31:0] src_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] result_o;
   logic        wr_en_o;
   logic [3:0]  status_o;

   int checks = 0;
   int fails  = 0;
   logic [3:0] exp_status = 4'h0;

   typedef struct {
      logic [31:0] res;
      logic        wr;
      logic [3:0]  st;
      string       tag;
   } item_t;

   item_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu_flags u_int_alu_flags (
      .clk      (clk),
      .rst      (rst),
      .valid_i  (valid_i),
      .op_i     (op_i),
      .src_i    (src_i),
      .dst_i    (dst_i),
      .result_o (result_o),
      .wr_en_o  (wr_en_o),
      .status_o (status_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Reference model built from the requirement text.
   task automatic model(input logic v, input logic [2:0] op,
                        input logic [31:0] s, input logic [31:0] d,
                        output logic [31:0] r, output logic w,
                        output logic [3:0] st);
      logic z, n, c, o;
      c = 1'b0; o = 1'b0; r = 32'h0; w = 1'b0;
      case (op)
         3'd0: begin
            r = d + s;
            c = (r < s) || (r < d);
            o = (d[31] == s[31]) && (r[31] != d[31]);
            w = v;
         end
         3'd1, 3'd2: begin
            r = d - s;
            c = (s > d);
            o = (d[31] != s[31]) && (r[31] != d[31]);
            w = v && (op == 3'd1);
         end
         3'd3: begin r = d | s; w = v; end
         3'd4: begin r = d ^ s; w = v; end
         3'd5: begin r = d & s; end
         default: begin r = 32'h0; end
      endcase
      z = (r == 32'h0);
      n = r[31];
      if (v && op <= 3'd5) st = {o, c, n, z};
      else                 st = exp_status;
   endtask

   // Driver: apply one operation at a falling edge, push the expectation.
   task automatic drive(input string tag, input logic v, input logic [2:0] op,
                        input logic [31:0] s, input logic [31:0] d);
      item_t it;
      logic [31:0] r;
      logic w;
      logic [3:0] st;
      @(negedge clk);
      valid_i = v; op_i = op; src_i = s; dst_i = d;
      model(v, op, s, d, r, w, st);
      exp_status = st;
      it.res = r; it.wr = w; it.st = st; it.tag = tag;
      sbq.push_back(it);
   endtask

   // Monitor: compare combinational outputs at the edge, status just after.
   initial begin
      forever begin
         @(posedge clk);
         if (sbq.size() > 0) begin
            item_t it;
            logic [31:0] r_s;
            logic w_s;
            it = sbq.pop_front();
            r_s = result_o;
            w_s = wr_en_o;
            #1;
            check(it.tag, "result", r_s, it.res);
            check(it.tag, "wr_en", {31'h0, w_s}, {31'h0, it.wr});
            check(it.tag, "status", {28'h0, status_o}, {28'h0, it.st});
         end
      end
   end

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst = 1'b1; valid_i = 1'b0;
      @(posedge clk); #1;
      check(tag, "status after reset", {28'h0, status_o}, 32'h0);
      exp_status = 4'h0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset("R10");
      // R1 add, plain and unsigned wrap to zero
      drive("R1", 1, 3'd0, 32'd1, 32'd1);
      drive("R1", 1, 3'd0, 32'd1, 32'hFFFF_FFFF);
      // R2 signed overflow positive side, and double sign-bit wrap
      drive("R2", 1, 3'd0, 32'd1, 32'h7FFF_FFFF);
      drive("R2", 1, 3'd0, 32'h8000_0000, 32'h8000_0000);
      drive("R2", 1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001);
      // R3 subtract, with and without borrow
      drive("R3", 1, 3'd1, 32'd3, 32'd5);
      drive("R3", 1, 3'd1, 32'd5, 32'd3);
      // R4 subtract overflow from both sides
      drive("R4", 1, 3'd1, 32'd1, 32'h8000_0000);
      drive("R4", 1, 3'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      // R5 compare equal, and first operand above second
      drive("R5", 1, 3'd2, 32'h1234_5678, 32'h1234_5678);
      drive("R5", 1, 3'd2, 32'h9000_0000, 32'h0000_0010);
      // R6 logic after C/V set: must clear them
      drive("R6", 1, 3'd0, 32'h8000_0000, 32'h8000_0000);
      drive("R6", 1, 3'd3, 32'h0000_00F0, 32'h8000_000F);
      drive("R6", 1, 3'd0, 32'h8000_0000, 32'h8000_0000);
      drive("R6", 1, 3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
      // R7 bit-test zero and sign cases
      drive("R7", 1, 3'd1, 32'd5, 32'd3);
      drive("R7", 1, 3'd5, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
      drive("R7", 1, 3'd5, 32'h8000_0001, 32'hC000_0000);
      // R8 every flag rebuilt: N,C set then plain positive add
      drive("R8", 1, 3'd1, 32'd5, 32'd3);
      drive("R8", 1, 3'd0, 32'd2, 32'd2);
      // R9 idle cycles hold the status
      drive("R9", 1, 3'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      drive("R9", 0, 3'd3, 32'h0, 32'h0);
      drive("R9", 0, 3'd0, 32'd7, 32'd9);
      // R11 reserved codes with strobe high
      drive("R11", 1, 3'd6, 32'h1111_1111, 32'h2222_2222);
      drive("R11", 1, 3'd7, 32'h0, 32'h0);
      // R12 no write-enable while strobe low
      drive("R12", 0, 3'd1, 32'd1, 32'd2);
      drive("R12", 0, 3'd4, 32'hFF, 32'h0F);
      @(negedge clk);
      valid_i = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      // R10 reset clears a non-zero status mid-run
      drive("R10", 1, 3'd0, 32'h8000_0000, 32'h8000_0000);
      @(negedge clk);
      valid_i = 1'b0;
      do_reset("R10");
      repeat (2) @(posedge clk);
      #2;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule